// File: doc/BRIEF.md
# Interrupt Arbiter and Exception Entry Sequencer

This block sits beside a processor core. It chooses which peripheral interrupt is serviced, and it performs the stack and vector work that takes the core into a handler and back out again. Each cycle it scans a fixed-order list of sources. A source qualifies when its request flag and its enable are both set. The first qualifying source supplies the vector number. The list holds a parameterised set of generic sources first, then four serial-port sources decoded from a status byte and a control byte.

The core pulses `insn_done` at each instruction boundary. At that pulse, if a source is pending and the mask bit of the status byte is clear, the block runs an entry sequence. It pushes one 32-bit word that holds the status byte in its top 8 bits and the program counter below. In extended mode it also pushes a 16-bit copy of the extended status byte. It then fetches the handler address from the vector table. A single-cycle `upd_valid` strobe hands the new PC, SP, status and extended status back to the core. A `rte_req` pulse runs the reverse pop sequence. In extended mode, a trace bit in the extended status forces a fixed-vector exception after the next instruction.

Top module: `irq_entry_ctrl`

## Requirements
- R1: Priority and vector numbering.
  - Generic source i qualifies when `ext_flag[i]` and `ext_en[i]` are both 1. Generic sources rank highest, lowest index first. Generic source i has vector 32+i.
  - The serial sources come next, with vectors 52 to 55 in this order: receive error, receive full, transmit empty, transmit end.
  - When nothing qualifies, `irq_pending` is 0 and `vec_out` is 0.
- R2: Serial source decoding from `ser_stat` (flag) and `ser_ctl` (enable):
  - Receive error: any of `ser_stat` bits 5..3, with `ser_ctl` bit 6.
  - Receive full: `ser_stat` bit 6, with `ser_ctl` bit 6.
  - Transmit empty: bit 7 of each byte.
  - Transmit end: bit 2 of each byte.
- R3: An interrupt entry starts only on an `insn_done` pulse while idle, with `irq_pending` 1 and `ccr_in` bit 7 (mask) at 0. With the mask set, no sequence starts and no memory access occurs.
- R4: The first cycle of an entry issues a 32-bit write of `{ccr_in, pc_in}` at `sp_in - 4`. Words are stored big-endian.
- R5: With `ext_mode` at 1, the next cycle issues a 16-bit write of `{exr_in, exr_in}` at `sp_in - 6`. With `ext_mode` at 0, no such write occurs.
- R6: Handler fetch depends on `wide_mode`.
  - At 1: a 32-bit read at vector×4, with the new PC taken from read bits 23..0.
  - At 0: a 16-bit read at vector×2, zero-extended to 24 bits.
- R7: The entry ends with one `upd_valid` cycle carrying:
  - the handler PC;
  - SP equal to `sp_in - 4`, or `sp_in - 6` in extended mode;
  - `ccr_in` with bit 7 set;
  - the extended status.
- R8: A `rte_req` pulse while idle pops the stack.
  - With `ext_mode` at 1, it first reads 16 bits at SP and takes the upper byte as the extended status.
  - It then reads 32 bits at SP+2 (extended) or at SP (otherwise). Bits 31..24 restore the status and bits 23..0 restore the PC.
  - `sp_out` is `sp_in + 6` (extended) or `sp_in + 4` (otherwise). Outside extended mode, `exr_out` equals `exr_in`.
- R9: Trace exception.
  - In extended mode, `exr_in` bit 7 seen at one `insn_done` arms a trace. The next `insn_done` then takes a vector 5 entry regardless of the mask.
  - The pushed extended word keeps bit 7 set. `exr_out` has bit 7 cleared and bits 6..0 unchanged.
  - Any entry disarms the trace.
- R10: When an unmasked interrupt and an armed trace meet at the same `insn_done`, the interrupt is taken.
- R11: While `busy` is 1, `insn_done` and `rte_req` are ignored. `upd_valid` is a single-cycle pulse with `busy` at 0.
- R12: Counted from the clock edge that accepts the request, `upd_valid` appears after:
  - 5 cycles for an extended entry, 4 for a plain entry;
  - 4 cycles for an extended return, 3 for a plain return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_flag | input | N_EXT | Generic source request flags |
| ext_en | input | N_EXT | Generic source enables |
| ser_stat | input | 8 | Serial port status byte (flags) |
| ser_ctl | input | 8 | Serial port control byte (enables) |
| wide_mode | input | 1 | 1: 4-byte vector entries; 0: 2-byte entries |
| ext_mode | input | 1 | 1: extended status is stacked and trace is active |
| insn_done | input | 1 | Instruction boundary pulse |
| rte_req | input | 1 | Return-from-exception request pulse |
| pc_in | input | 24 | Current program counter |
| ccr_in | input | 8 | Current status byte; bit 7 is the interrupt mask |
| exr_in | input | 8 | Current extended status; bit 7 trace, bits 2..0 level |
| sp_in | input | ADDR_W | Current stack pointer |
| irq_pending | output | 1 | A qualifying source exists |
| vec_out | output | VEC_W | Vector of the winning source, 0 if none |
| busy | output | 1 | A sequence is in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_wide | output | 1 | 1: 32-bit access; 0: 16-bit access |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 32 | Write data (16-bit data in bits 15..0) |
| mem_rdata | input | 32 | Read data, valid the cycle after the read |
| upd_valid | output | 1 | New register values are valid |
| pc_out | output | 24 | New program counter |
| ccr_out | output | 8 | New status byte |
| exr_out | output | 8 | New extended status |
| sp_out | output | ADDR_W | New stack pointer |

## Verification
The assertions take three things for granted about the inputs:
- `pc_in`, `ccr_in`, `exr_in` and `sp_in` hold steady from the accepting edge through the first sequence cycle. This is what lets the frame-word check compare the write against the values sampled one cycle earlier.
- Memory returns read data exactly one cycle after the read.
- `insn_done` and `rte_req` never arrive together.

The stimulus changes register inputs only between sequences, answers reads from a one-cycle model, and raises a request during a sequence only to confirm that it is ignored.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int PC_W      = 24;
    localparam int MASK_BIT  = 7;
    localparam int TRACE_BIT = 7;
    localparam int N_SER     = 4;
    localparam int TRACE_VEC = 5;

    // serial sources in priority order: rx error, rx full, tx empty, tx end
    localparam logic [7:0] SER_FLAG_MASK [N_SER] = '{8'h38, 8'h40, 8'h80, 8'h04};
    localparam logic [7:0] SER_EN_MASK   [N_SER] = '{8'h40, 8'h40, 8'h80, 8'h04};

    typedef enum logic [2:0] {
        S_IDLE       = 3'd0,
        S_PUSH_FRAME = 3'd1,
        S_PUSH_EXT   = 3'd2,
        S_FETCH_VEC  = 3'd3,
        S_LOAD_PC    = 3'd4,
        S_POP_EXT    = 3'd5,
        S_POP_FRAME  = 3'd6,
        S_POP_DONE   = 3'd7
    } seq_state_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_entry_pkg::*;
#(
    parameter int N_EXT    = 4,
    parameter int VEC_W    = 8,
    parameter int EXT_BASE = 32,
    parameter int SER_BASE = 52
) (
    input  logic [N_EXT-1:0] ext_flag,
    input  logic [N_EXT-1:0] ext_en,
    input  logic [7:0]       ser_stat,
    input  logic [7:0]       ser_ctl,
    output logic             hit,
    output logic [VEC_W-1:0] vec
);
    localparam int N_ALL = N_EXT + N_SER;

    logic [N_ALL-1:0] live;
    logic [VEC_W-1:0] vec_of [N_ALL];

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        assign live[g]   = ext_flag[g] & ext_en[g];
        assign vec_of[g] = VEC_W'(EXT_BASE + g);
    end

    for (genvar g = 0; g < N_SER; g++) begin : g_ser
        assign live[N_EXT+g]   = (|(ser_stat & SER_FLAG_MASK[g])) &
                                 (|(ser_ctl & SER_EN_MASK[g]));
        assign vec_of[N_EXT+g] = VEC_W'(SER_BASE + g);
    end

    // walk from lowest priority up so the lowest index is written last
    always_comb begin
        hit = 1'b0;
        vec = '0;
        for (int i = N_ALL - 1; i >= 0; i--) begin
            if (live[i]) begin
                hit = 1'b1;
                vec = vec_of[i];
            end
        end
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              rte_req,
    input  logic              wide_mode,
    input  logic              ext_mode,
    input  logic              irq_hit,
    input  logic [VEC_W-1:0]  irq_vec,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [7:0]        ccr_in,
    input  logic [7:0]        exr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              is_entry,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              upd_valid,
    output logic [PC_W-1:0]   pc_out,
    output logic [7:0]        ccr_out,
    output logic [7:0]        exr_out,
    output logic [ADDR_W-1:0] sp_out
);
    localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] EXT_BYTES   = ADDR_W'(2);

    typedef struct packed {
        seq_state_e        st;
        logic              entry;
        logic              ext;
        logic              wide;
        logic              by_trace;
        logic              trace_arm;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] sp;
        logic [PC_W-1:0]   pc;
        logic [7:0]        ccr;
        logic [7:0]        exr;
        logic              upd;
    } seq_t;

    seq_t q, d;
    logic take_irq, take_trc;

    always_comb begin
        d         = q;
        d.upd     = 1'b0;
        take_irq  = 1'b0;
        take_trc  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wide  = 1'b1;
        mem_addr  = q.sp;
        mem_wdata = '0;
        unique case (q.st)
            S_IDLE: begin
                if (rte_req) begin
                    d.entry = 1'b0;
                    d.ext   = ext_mode;
                    d.ccr   = ccr_in;
                    d.exr   = exr_in;
                    d.sp    = sp_in;
                    d.st    = ext_mode ? S_POP_EXT : S_POP_FRAME;
                end else if (insn_done) begin
                    take_irq = irq_hit && !ccr_in[MASK_BIT];
                    take_trc = ext_mode && q.trace_arm;
                    if (take_irq || take_trc) begin
                        d.entry     = 1'b1;
                        d.ext       = ext_mode;
                        d.wide      = wide_mode;
                        d.by_trace  = !take_irq;
                        d.vec       = take_irq ? irq_vec : VEC_W'(TRACE_VEC);
                        d.pc        = pc_in;
                        d.ccr       = ccr_in;
                        d.exr       = exr_in;
                        d.sp        = sp_in - FRAME_BYTES;
                        d.trace_arm = 1'b0;
                        d.st        = S_PUSH_FRAME;
                    end else begin
                        d.trace_arm = exr_in[TRACE_BIT];
                    end
                end
            end
            S_PUSH_FRAME: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {q.ccr, q.pc};
                if (q.ext) begin
                    d.sp = q.sp - EXT_BYTES;
                    d.st = S_PUSH_EXT;
                end else begin
                    d.st = S_FETCH_VEC;
                end
            end
            S_PUSH_EXT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wide  = 1'b0;
                mem_wdata = {16'h0000, q.exr, q.exr};
                d.st      = S_FETCH_VEC;
            end
            S_FETCH_VEC: begin
                mem_req  = 1'b1;
                mem_wide = q.wide;
                mem_addr = q.wide ? (ADDR_W'(q.vec) << 2) : (ADDR_W'(q.vec) << 1);
                d.st     = S_LOAD_PC;
            end
            S_LOAD_PC: begin
                d.pc  = q.wide ? mem_rdata[PC_W-1:0] : PC_W'(mem_rdata[15:0]);
                d.ccr = q.ccr | 8'h80;
                if (q.by_trace) d.exr[TRACE_BIT] = 1'b0;
                d.upd = 1'b1;
                d.st  = S_IDLE;
            end
            S_POP_EXT: begin
                mem_req  = 1'b1;
                mem_wide = 1'b0;
                d.sp     = q.sp + EXT_BYTES;
                d.st     = S_POP_FRAME;
            end
            S_POP_FRAME: begin
                if (q.ext) d.exr = mem_rdata[15:8];
                mem_req = 1'b1;
                d.sp    = q.sp + FRAME_BYTES;
                d.st    = S_POP_DONE;
            end
            S_POP_DONE: begin
                d.ccr = mem_rdata[31:24];
                d.pc  = mem_rdata[PC_W-1:0];
                d.upd = 1'b1;
                d.st  = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != S_IDLE);
    assign is_entry  = q.entry;
    assign upd_valid = q.upd;
    assign pc_out    = q.pc;
    assign ccr_out   = q.ccr;
    assign exr_out   = q.exr;
    assign sp_out    = q.sp;
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int N_EXT    = 4,
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 24,
    parameter int EXT_BASE = 32,
    parameter int SER_BASE = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EXT-1:0]  ext_flag,
    input  logic [N_EXT-1:0]  ext_en,
    input  logic [7:0]        ser_stat,
    input  logic [7:0]        ser_ctl,
    input  logic              wide_mode,
    input  logic              ext_mode,
    input  logic              insn_done,
    input  logic              rte_req,
    input  logic [23:0]       pc_in,
    input  logic [7:0]        ccr_in,
    input  logic [7:0]        exr_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              irq_pending,
    output logic [VEC_W-1:0]  vec_out,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              upd_valid,
    output logic [23:0]       pc_out,
    output logic [7:0]        ccr_out,
    output logic [7:0]        exr_out,
    output logic [ADDR_W-1:0] sp_out
);
    logic seq_entry;

    irq_pick #(
        .N_EXT(N_EXT), .VEC_W(VEC_W), .EXT_BASE(EXT_BASE), .SER_BASE(SER_BASE)
    ) u_pick (
        .ext_flag(ext_flag), .ext_en(ext_en),
        .ser_stat(ser_stat), .ser_ctl(ser_ctl),
        .hit(irq_pending), .vec(vec_out)
    );

    exc_seq #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .insn_done(insn_done), .rte_req(rte_req),
        .wide_mode(wide_mode), .ext_mode(ext_mode),
        .irq_hit(irq_pending), .irq_vec(vec_out),
        .pc_in(pc_in), .ccr_in(ccr_in), .exr_in(exr_in), .sp_in(sp_in),
        .mem_rdata(mem_rdata),
        .busy(busy), .is_entry(seq_entry),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .upd_valid(upd_valid), .pc_out(pc_out), .ccr_out(ccr_out),
        .exr_out(exr_out), .sp_out(sp_out)
    );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int ADDR_W = 24,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_mode,
    input logic              insn_done,
    input logic              rte_req,
    input logic [23:0]       pc_in,
    input logic [7:0]        ccr_in,
    input logic [ADDR_W-1:0] sp_in,
    input logic              irq_pending,
    input logic [VEC_W-1:0]  vec_out,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_wide,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              upd_valid,
    input logic [7:0]        ccr_out,
    input logic              is_entry
);
    // R1
    no_source_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> vec_out == '0);

    // R3
    masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !rte_req && ccr_in[7] && !ext_mode) |=> !busy);

    // R3
    unmasked_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !rte_req && irq_pending && !ccr_in[7]) |=> (busy && is_entry));

    // R4
    frame_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && is_entry) |-> (mem_req && mem_we && mem_wide &&
            mem_addr == $past(sp_in) - ADDR_W'(4) &&
            mem_wdata == {$past(ccr_in), $past(pc_in)}));

    // R5
    ext_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_wide) |->
            (mem_wdata[15:8] == mem_wdata[7:0] && mem_addr == $past(mem_addr) - ADDR_W'(2)));

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && is_entry) |-> ccr_out[7]);

    // R11
    upd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !busy);

    // R11
    upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

bind irq_entry_ctrl irq_entry_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .insn_done(insn_done),
    .rte_req(rte_req), .pc_in(pc_in), .ccr_in(ccr_in), .sp_in(sp_in),
    .irq_pending(irq_pending), .vec_out(vec_out), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .upd_valid(upd_valid),
    .ccr_out(ccr_out), .is_entry(seq_entry)
);

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;
    localparam int N_EXT  = 4;
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_EXT-1:0]  ext_flag = '0, ext_en = '0;
    logic [7:0]        ser_stat = '0, ser_ctl = '0;
    logic              wide_mode = 1'b1, ext_mode = 1'b0;
    logic              insn_done = 1'b0, rte_req = 1'b0;
    logic [23:0]       pc_in = '0;
    logic [7:0]        ccr_in = '0, exr_in = '0;
    logic [ADDR_W-1:0] sp_in = '0;
    logic              irq_pending, busy, mem_req, mem_we, mem_wide, upd_valid;
    logic [VEC_W-1:0]  vec_out;
    logic [ADDR_W-1:0] mem_addr, sp_out;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic [23:0]       pc_out;
    logic [7:0]        ccr_out, exr_out;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_entry_ctrl #(.N_EXT(N_EXT), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_flag(ext_flag), .ext_en(ext_en),
        .ser_stat(ser_stat), .ser_ctl(ser_ctl), .wide_mode(wide_mode),
        .ext_mode(ext_mode), .insn_done(insn_done), .rte_req(rte_req),
        .pc_in(pc_in), .ccr_in(ccr_in), .exr_in(exr_in), .sp_in(sp_in),
        .irq_pending(irq_pending), .vec_out(vec_out), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .upd_valid(upd_valid), .pc_out(pc_out), .ccr_out(ccr_out),
        .exr_out(exr_out), .sp_out(sp_out)
    );

    // big-endian byte memory, read data one cycle after the request
    logic [7:0] mem [0:4095];
    logic [11:0] ma;
    assign ma = mem_addr[11:0];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            if (mem_wide) begin
                mem[ma]         <= mem_wdata[31:24];
                mem[ma+12'd1]   <= mem_wdata[23:16];
                mem[ma+12'd2]   <= mem_wdata[15:8];
                mem[ma+12'd3]   <= mem_wdata[7:0];
            end else begin
                mem[ma]         <= mem_wdata[15:8];
                mem[ma+12'd1]   <= mem_wdata[7:0];
            end
        end
        if (mem_req && !mem_we)
            mem_rdata <= mem_wide ? {mem[ma], mem[ma+12'd1], mem[ma+12'd2], mem[ma+12'd3]}
                                  : {16'h0000, mem[ma], mem[ma+12'd1]};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        mem[a] = v[31:24]; mem[a+1] = v[23:16]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0];
    endtask

    task automatic put16(input int a, input logic [15:0] v);
        mem[a] = v[15:8]; mem[a+1] = v[7:0];
    endtask

    function automatic logic [31:0] get32(input int a);
        return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endfunction

    function automatic logic [15:0] get16(input int a);
        return {mem[a], mem[a+1]};
    endfunction

    // raise a one-cycle pulse; returns at the first negedge after the accepting edge
    task automatic pulse(input bit is_rte);
        @(negedge clk);
        if (is_rte) rte_req = 1'b1; else insn_done = 1'b1;
        @(negedge clk);
        rte_req = 1'b0;
        insn_done = 1'b0;
    endtask

    task automatic wait_upd(inout int cnt);
        while (!upd_valid && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    typedef struct packed {
        logic [3:0] ef;
        logic [3:0] en;
        logic [7:0] st;
        logic [7:0] ct;
        logic [7:0] vec;
    } scan_t;

    localparam int N_SCAN = 11;
    localparam scan_t SCAN_TBL [N_SCAN] = '{
        '{4'b0000, 4'b0000, 8'h00, 8'h00, 8'd0},
        '{4'b0001, 4'b0001, 8'h00, 8'h00, 8'd32},
        '{4'b1010, 4'b1000, 8'h00, 8'h00, 8'd35},
        '{4'b1010, 4'b0101, 8'h80, 8'h80, 8'd54},
        '{4'b0000, 4'b0000, 8'h08, 8'h40, 8'd52},
        '{4'b0000, 4'b0000, 8'hC4, 8'hC4, 8'd53},
        '{4'b0000, 4'b0000, 8'h04, 8'h04, 8'd55},
        '{4'b0000, 4'b0000, 8'h84, 8'h04, 8'd55},
        '{4'b0000, 4'b0000, 8'h38, 8'h00, 8'd0},
        '{4'b0100, 4'b0100, 8'h20, 8'h40, 8'd34},
        '{4'b0000, 4'b0000, 8'hA0, 8'hC0, 8'd52}
    };

    initial begin
        #1_200_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R11)
        chk("R11 reset busy", 32'(busy), 32'd0);
        chk("R11 reset upd_valid", 32'(upd_valid), 32'd0);
        chk("R3 reset mem_req", 32'(mem_req), 32'd0);
        chk("R1 reset vec", 32'(vec_out), 32'd0);

        // R1 R2 scan table
        for (int i = 0; i < N_SCAN; i++) begin
            @(negedge clk);
            ext_flag = SCAN_TBL[i].ef;
            ext_en   = SCAN_TBL[i].en;
            ser_stat = SCAN_TBL[i].st;
            ser_ctl  = SCAN_TBL[i].ct;
            #1;
            chk($sformatf("R1 R2 scan vec row %0d", i), 32'(vec_out), 32'(SCAN_TBL[i].vec));
            chk($sformatf("R1 scan pending row %0d", i), 32'(irq_pending),
                32'(SCAN_TBL[i].vec != 8'd0));
        end

        // R3 masked: nothing happens
        ext_flag = 4'b0010; ext_en = 4'b0010; ser_stat = '0; ser_ctl = '0;
        ccr_in = 8'h80; ext_mode = 1'b0; sp_in = 24'h000800;
        pulse(1'b0);
        chk("R3 masked busy", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R3 masked no mem", 32'(mem_req), 32'd0);
        chk("R3 masked no upd", 32'(upd_valid), 32'd0);

        // wide + extended entry, vector 33 (R4 R5 R6 R7 R12)
        put32(33*4, 32'h55012340);
        wide_mode = 1'b1; ext_mode = 1'b1;
        ccr_in = 8'h05; exr_in = 8'h03; pc_in = 24'h001234; sp_in = 24'h000800;
        pulse(1'b0);
        chk("R3 entry busy", 32'(busy), 32'd1);
        cnt = 1;
        wait_upd(cnt);
        chk("R12 ext entry latency", 32'(cnt), 32'd5);
        chk("R4 frame word", get32(12'h7FC), 32'h05001234);
        chk("R5 ext word", 32'(get16(12'h7FA)), 32'h0303);
        chk("R6 wide pc", 32'(pc_out), 32'h012340);
        chk("R7 sp ext", 32'(sp_out), 32'h0007FA);
        chk("R7 ccr mask", 32'(ccr_out), 32'h85);
        chk("R7 exr", 32'(exr_out), 32'h03);
        @(negedge clk);
        chk("R11 upd single", 32'(upd_valid), 32'd0);

        // narrow + plain entry, vector 55, rte raised while busy (R5 R6 R11 R12)
        ext_flag = '0; ext_en = '0; ser_stat = 8'h04; ser_ctl = 8'h04;
        wide_mode = 1'b0; ext_mode = 1'b0;
        put16(55*2, 16'h4321);
        put16(12'h8FA, 16'hEEEE);
        ccr_in = 8'h02; exr_in = 8'h05; pc_in = 24'h000ABC; sp_in = 24'h000900;
        pulse(1'b0);
        rte_req = 1'b1;
        @(negedge clk);
        rte_req = 1'b0;
        cnt = 2;
        wait_upd(cnt);
        chk("R12 plain entry latency", 32'(cnt), 32'd4);
        chk("R4 frame narrow", get32(12'h8FC), 32'h02000ABC);
        chk("R5 no ext word", 32'(get16(12'h8FA)), 32'hEEEE);
        chk("R6 narrow pc", 32'(pc_out), 32'h004321);
        chk("R7 sp plain", 32'(sp_out), 32'h0008FC);
        chk("R7 ccr narrow", 32'(ccr_out), 32'h82);
        chk("R11 entry result kept", 32'(exr_out), 32'h05);
        @(negedge clk);
        chk("R11 rte ignored while busy", 32'(busy), 32'd0);
        ser_stat = '0; ser_ctl = '0;

        // extended return (R8 R12)
        wide_mode = 1'b1; ext_mode = 1'b1;
        put16(12'h600, 16'h8200);
        put32(12'h602, 32'h0700ABCD);
        sp_in = 24'h000600; ccr_in = 8'h80; exr_in = 8'h00;
        pulse(1'b1);
        cnt = 1;
        wait_upd(cnt);
        chk("R12 ext return latency", 32'(cnt), 32'd4);
        chk("R8 ext pc", 32'(pc_out), 32'h00ABCD);
        chk("R8 ext ccr", 32'(ccr_out), 32'h07);
        chk("R8 ext exr", 32'(exr_out), 32'h82);
        chk("R8 ext sp", 32'(sp_out), 32'h000606);

        // plain return (R8 R12)
        ext_mode = 1'b0;
        put32(12'h700, 32'h01123456);
        sp_in = 24'h000700; exr_in = 8'h44;
        pulse(1'b1);
        cnt = 1;
        wait_upd(cnt);
        chk("R12 plain return latency", 32'(cnt), 32'd3);
        chk("R8 plain pc", 32'(pc_out), 32'h123456);
        chk("R8 plain ccr", 32'(ccr_out), 32'h01);
        chk("R8 plain exr", 32'(exr_out), 32'h44);
        chk("R8 plain sp", 32'(sp_out), 32'h000704);

        // trace (R9)
        ext_mode = 1'b1; wide_mode = 1'b1; ccr_in = 8'h80; exr_in = 8'h81;
        pc_in = 24'h000222; sp_in = 24'h000A00;
        put32(5*4, 32'h00003000);
        pulse(1'b0);
        chk("R9 arm no entry", 32'(busy), 32'd0);
        pulse(1'b0);
        chk("R9 trace entry busy", 32'(busy), 32'd1);
        cnt = 1;
        wait_upd(cnt);
        chk("R9 trace pc", 32'(pc_out), 32'h003000);
        chk("R9 trace exr cleared", 32'(exr_out), 32'h01);
        chk("R9 pushed exr keeps trace", 32'(get16(12'h9FA)), 32'h8181);
        chk("R9 trace frame", get32(12'h9FC), 32'h80000222);
        chk("R9 trace sp", 32'(sp_out), 32'h0009FA);
        pulse(1'b0);
        chk("R9 disarmed after entry", 32'(busy), 32'd0);

        // trace armed by previous pulse, unmasked irq wins (R10)
        ccr_in = 8'h00; ext_flag = 4'b0010; ext_en = 4'b0010; sp_in = 24'h000B00;
        pulse(1'b0);
        cnt = 1;
        wait_upd(cnt);
        chk("R10 irq over trace pc", 32'(pc_out), 32'h012340);
        chk("R10 exr untouched", 32'(exr_out), 32'h81);
        exr_in = 8'h00; ext_flag = '0; ext_en = '0;
        pulse(1'b0);
        chk("R9 R10 trace disarmed by irq entry", 32'(busy), 32'd0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule